// File: doc/BRIEF.md
# Auto-Incrementing Serial Register Bank with RAM Window

This block is the register bank that a serial-bus byte engine talks to. The bus engine turns the wire protocol into byte events: a transaction opens, a start address is loaded, data bytes are written or read, and the transaction closes. The bank holds thirty byte-wide locations at addresses 00h to 1Dh. Its address pointer steps forward by itself after every data byte, so a host can sweep a run of registers in one transaction.

Four addresses at the top of the map form a window onto a 512-byte general-purpose RAM. Two of them hold a 9-bit RAM pointer. The other two are command addresses: bytes written at one are stored into the RAM, and bytes read at the other are fetched from it. The RAM pointer advances after each byte, so one transaction can move a whole stream of bytes.

The calendar counters live at addresses 03h to 09h. While a transaction is open, the bank holds back their one-second increment, so a host always sees a coherent time snapshot. One increment request that arrives during the transaction is kept. It is released as a single `time_step` pulse once the transaction closes. The calendar arithmetic itself sits outside the block and acts on `time_step`.

Top module: `serreg_bank`

## Requirements
- R1: After reset the address pointer is 00h, the RAM pointer is 000h, every register reads 00h, `rd_data` is 00h and `time_step` is low.
- R2: Each data byte (`wr_stb` or `rd_stb`) moves the address pointer to the next address. From 1Bh it goes to 00h instead of 1Ch.
- R3: Addresses 1Ch and 1Dh are reached only through `addr_load`. While the pointer is at either of them, data bytes leave it unchanged.
- R4: Bit 0 of address 1Ah is RAM pointer bit 8, and address 1Bh is RAM pointer bits 7:0. Both are writable. Both read back the current RAM pointer, including any advance made by streaming. Bits 7:1 of 1Ah read 0.
- R5: A byte written while the pointer is at 1Ch is stored in the RAM at the RAM pointer. A byte read while the pointer is at 1Dh returns the RAM content at the RAM pointer.
- R6: Every byte moved through 1Ch or 1Dh advances the RAM pointer by one. The RAM pointer wraps from 1FFh to 000h.
- R7: Bit positions with no storage read 0 and ignore writes. The readable masks are: 03h and 04h use 7Fh; 05h and 06h use 3Fh; 07h uses 07h; 08h uses 1Fh. Every other plain register below 1Ah uses FFh.
- R8: While a transaction is open (from `xfer_start` to `xfer_end`), `time_step` stays low. When no transaction is open, a `tick_req` produces `time_step` high in the following cycle.
- R9: At most one `tick_req` that arrives during a transaction is held, and any further ones are dropped. A held request produces exactly one `time_step` pulse in the cycle after `xfer_end`.
- R10: Reads at 1Ch, 1Eh and 1Fh return 00h, and writes there change no register. The pointer steps from 1Eh to 1Fh and then to 00h.
- R11: Read data appears on `rd_data` in the cycle after `rd_stb` and holds until the next `rd_stb`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Pulse: a bus transaction opened |
| xfer_end | input | 1 | Pulse: stop condition or chip deselect |
| addr_load | input | 1 | Pulse: load `addr_in` as the start address |
| addr_in | input | 5 | Start address |
| wr_stb | input | 1 | Pulse: write data byte at the pointer |
| wr_data | input | 8 | Write data byte |
| rd_stb | input | 1 | Pulse: read data byte at the pointer |
| rd_data | output | 8 | Read data, valid the cycle after `rd_stb` |
| tick_req | input | 1 | One-second increment request from the prescaler |
| time_step | output | 1 | Pulse: the calendar counters may increment now |

## Verification
The address pointer is visible only through where the next byte lands. A wrong step or a wrong wrap therefore shows up on the very next read, as a byte from an unexpected register. A corrupted RAM pointer is visible in two ways: at once, by reading back 1Ah and 1Bh, and one streamed byte later, as misplaced data when the stream is read back. The freeze logic shows on `time_step` within one cycle of a tick or of `xfer_end`. A held request that is lost or doubled shows as a missing or extra pulse right after the transaction closes.

// File: rtl/serreg_pkg.sv
package serreg_pkg;
  localparam int ADDR_W = 5;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_RPTR_HI = 5'h1A;
  localparam logic [ADDR_W-1:0] A_RPTR_LO = 5'h1B;
  localparam logic [ADDR_W-1:0] A_RAM_WR  = 5'h1C;
  localparam logic [ADDR_W-1:0] A_RAM_RD  = 5'h1D;
  localparam int PLAIN_N = 26;  // plain registers 00h..19h

  // pointer after one data byte
  function automatic logic [ADDR_W-1:0] ptr_next(input logic [ADDR_W-1:0] p);
    if (p == A_RAM_WR || p == A_RAM_RD) return p;
    if (p == A_RPTR_LO) return '0;
    return p + 1'b1;
  endfunction

  // implemented bits of each plain register
  function automatic logic [DATA_W-1:0] field_mask(input logic [ADDR_W-1:0] a);
    case (a)
      5'h03, 5'h04: return 8'h7F;
      5'h05, 5'h06: return 8'h3F;
      5'h07:        return 8'h07;
      5'h08:        return 8'h1F;
      default:      return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/serreg_addr_ptr.sv
module serreg_addr_ptr
  import serreg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] load_addr,
  input  logic              step,
  output logic [ADDR_W-1:0] ptr
);
  always_ff @(posedge clk) begin
    if (!rst_n)    ptr <= '0;
    else if (load) ptr <= load_addr;
    else if (step) ptr <= ptr_next(ptr);
  end
endmodule

// File: rtl/serreg_ram.sv
module serreg_ram #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    if (re) q <= mem[addr];
  end
endmodule

// File: rtl/serreg_tick_gate.sv
module serreg_tick_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic xfer_start,
  input  logic xfer_end,
  input  logic tick_req,
  output logic busy,
  output logic pending,
  output logic time_step
);
  logic held;
  assign held = pending | tick_req;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      pending   <= 1'b0;
      time_step <= 1'b0;
    end else begin
      if (busy) begin
        time_step <= xfer_end & held;
        pending   <= ~xfer_end & held;
      end else begin
        time_step <= tick_req;
        pending   <= 1'b0;
      end
      if (xfer_start)    busy <= 1'b1;
      else if (xfer_end) busy <= 1'b0;
    end
  end
endmodule

// File: rtl/serreg_bank.sv
module serreg_bank
  import serreg_pkg::*;
#(
  parameter int RAM_AW = 9
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        xfer_start,
  input  logic        xfer_end,
  input  logic        addr_load,
  input  logic [4:0]  addr_in,
  input  logic        wr_stb,
  input  logic [7:0]  wr_data,
  input  logic        rd_stb,
  output logic [7:0]  rd_data,
  input  logic        tick_req,
  output logic        time_step
);
  localparam int HI_W = RAM_AW - 8;

  logic [ADDR_W-1:0] ptr_q;
  logic [RAM_AW-1:0] rptr_q;
  logic [DATA_W-1:0] regs [PLAIN_N];
  logic [DATA_W-1:0] reg_q, ram_q, reg_rd_val;
  logic              rd_src_ram;
  logic              busy_w, pending_w;

  // named events for the checker
  logic byte_acc, ram_wr, ram_rd, ram_acc, plain_wr;
  assign byte_acc = (wr_stb | rd_stb) & ~addr_load;
  assign ram_wr   = wr_stb & ~addr_load & (ptr_q == A_RAM_WR);
  assign ram_rd   = rd_stb & ~wr_stb & ~addr_load & (ptr_q == A_RAM_RD);
  assign ram_acc  = ram_wr | ram_rd;
  assign plain_wr = wr_stb & ~addr_load & (ptr_q < ADDR_W'(PLAIN_N));

  serreg_addr_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(addr_load), .load_addr(addr_in),
    .step(byte_acc), .ptr(ptr_q)
  );

  serreg_ram #(.AW(RAM_AW), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ram_wr), .re(ram_rd), .addr(rptr_q),
    .wdata(wr_data), .q(ram_q)
  );

  serreg_tick_gate u_gate (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .tick_req(tick_req), .busy(busy_w), .pending(pending_w),
    .time_step(time_step)
  );

  // RAM pointer
  always_ff @(posedge clk) begin
    if (!rst_n) rptr_q <= '0;
    else if (wr_stb && !addr_load && ptr_q == A_RPTR_HI)
      rptr_q[RAM_AW-1:8] <= wr_data[HI_W-1:0];
    else if (wr_stb && !addr_load && ptr_q == A_RPTR_LO)
      rptr_q[7:0] <= wr_data;
    else if (ram_acc)
      rptr_q <= rptr_q + 1'b1;
  end

  // plain registers
  for (genvar g = 0; g < PLAIN_N; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (!rst_n) regs[g] <= '0;
      else if (plain_wr && ptr_q == ADDR_W'(g))
        regs[g] <= wr_data & field_mask(ADDR_W'(g));
    end
  end

  always_comb begin
    reg_rd_val = '0;
    if (ptr_q < ADDR_W'(PLAIN_N)) reg_rd_val = regs[ptr_q];
    else if (ptr_q == A_RPTR_HI)  reg_rd_val = DATA_W'(rptr_q[RAM_AW-1:8]);
    else if (ptr_q == A_RPTR_LO)  reg_rd_val = rptr_q[7:0];
  end

  // read path
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reg_q      <= '0;
      rd_src_ram <= 1'b0;
    end else if (rd_stb && !wr_stb && !addr_load) begin
      reg_q      <= reg_rd_val;
      rd_src_ram <= ram_rd;
    end
  end

  assign rd_data = rd_src_ram ? ram_q : reg_q;
endmodule

// File: rtl/serreg_bank_chk.sv
module serreg_bank_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] ptr_q,
  input logic       byte_acc,
  input logic       ram_acc,
  input logic [8:0] rptr_q,
  input logic       busy_w,
  input logic       pending_w,
  input logic       xfer_end,
  input logic       tick_req,
  input logic       time_step
);
  AST_PTR_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && ptr_q == 5'h1B) |=> (ptr_q == 5'h00));  // R2
  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_acc && (ptr_q == 5'h1C || ptr_q == 5'h1D)) |=> $stable(ptr_q));  // R3
  AST_RPTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ram_acc |=> (rptr_q == $past(rptr_q) + 9'd1));  // R6
  AST_NO_STEP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    time_step |-> ($past(tick_req && !busy_w) || $past(busy_w && xfer_end)));  // R8
  AST_PEND_IN_XFER: assert property (@(posedge clk) disable iff (!rst_n)
    pending_w |-> busy_w);  // R9
endmodule

bind serreg_bank serreg_bank_chk chk_i (
  .clk(clk), .rst_n(rst_n), .ptr_q(ptr_q), .byte_acc(byte_acc),
  .ram_acc(ram_acc), .rptr_q(rptr_q), .busy_w(busy_w),
  .pending_w(pending_w), .xfer_end(xfer_end), .tick_req(tick_req),
  .time_step(time_step)
);

// File: tb/serreg_bank_tb.sv
module serreg_bank_tb_top;
  logic clk = 0, rst_n = 0;
  logic xfer_start = 0, xfer_end = 0, addr_load = 0, wr_stb = 0, rd_stb = 0;
  logic tick_req = 0;
  logic [4:0] addr_in = 0;
  logic [7:0] wr_data = 0;
  logic [7:0] rd_data;
  logic time_step;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;  // 50 MHz

  serreg_bank dut_i (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_end(xfer_end),
    .addr_load(addr_load), .addr_in(addr_in), .wr_stb(wr_stb),
    .wr_data(wr_data), .rd_stb(rd_stb), .rd_data(rd_data),
    .tick_req(tick_req), .time_step(time_step)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic pulse_start();
    xfer_start = 1; @(negedge clk); xfer_start = 0;
  endtask
  task automatic pulse_end();
    xfer_end = 1; @(negedge clk); xfer_end = 0;
  endtask
  task automatic load(input logic [4:0] a);
    addr_load = 1; addr_in = a; @(negedge clk); addr_load = 0;
  endtask
  task automatic wr(input logic [7:0] d);
    wr_stb = 1; wr_data = d; @(negedge clk); wr_stb = 0;
  endtask
  task automatic rd(output logic [7:0] d);
    rd_stb = 1; @(negedge clk); rd_stb = 0; d = rd_data;
  endtask
  task automatic rd_at(input logic [4:0] a, output logic [7:0] d);
    pulse_start(); load(a); rd(d); pulse_end();
  endtask
  task automatic wr_at(input logic [4:0] a, input logic [7:0] d);
    pulse_start(); load(a); wr(d); pulse_end();
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk("R1 time_step", {7'd0, time_step}, 8'h00);
    chk("R1 rd_data", rd_data, 8'h00);
    pulse_start(); rd(v); chk("R1 reg00", v, 8'h00);
    rd(v); chk("R1 reg01 auto", v, 8'h00); pulse_end();
    rd_at(5'h1B, v); chk("R1 rptr lo", v, 8'h00);
  endtask

  task automatic t_autoinc();
    logic [7:0] v;
    pulse_start(); load(5'h0A); wr(8'h11); wr(8'h22); wr(8'h33); pulse_end();
    pulse_start(); load(5'h0A);
    rd(v); chk("R2 0Ah", v, 8'h11);
    rd(v); chk("R2 0Bh", v, 8'h22);
    rd(v); chk("R2 0Ch", v, 8'h33);
    repeat (3) @(negedge clk);
    chk("R11 hold", rd_data, 8'h33);
    pulse_end();
    pulse_start(); load(5'h1B); wr(8'h04); wr(8'hC3); pulse_end();
    rd_at(5'h00, v); chk("R2 wrap 1Bh->00h", v, 8'hC3);
  endtask

  task automatic t_masks();
    logic [7:0] v;
    wr_at(5'h05, 8'hFF); rd_at(5'h05, v); chk("R7 05h", v, 8'h3F);
    wr_at(5'h07, 8'hFF); rd_at(5'h07, v); chk("R7 07h", v, 8'h07);
    wr_at(5'h03, 8'hFF); rd_at(5'h03, v); chk("R7 03h", v, 8'h7F);
    wr_at(5'h08, 8'hFF); rd_at(5'h08, v); chk("R7 08h", v, 8'h1F);
    wr_at(5'h1A, 8'hFF); rd_at(5'h1A, v); chk("R4 1Ah mask", v, 8'h01);
  endtask

  task automatic t_ram();
    logic [7:0] v;
    pulse_start(); load(5'h1A); wr(8'h01); wr(8'hFF); pulse_end();
    pulse_start(); load(5'h1C); wr(8'hA5); wr(8'h5A); wr(8'h3C); rd(v); pulse_end();
    chk("R10 read 1Ch", v, 8'h00);
    rd_at(5'h1A, v); chk("R6 rptr hi after wrap", v, 8'h00);
    rd_at(5'h1B, v); chk("R6 rptr lo after wrap", v, 8'h02);
    pulse_start(); load(5'h1A); wr(8'h01); wr(8'hFF); pulse_end();
    pulse_start(); load(5'h1D);
    rd(v); chk("R5 ram 1FFh", v, 8'hA5);
    rd(v); chk("R5 ram 000h", v, 8'h5A);
    rd(v); chk("R3 ptr held at 1Dh", v, 8'h3C);
    pulse_end();
    rd_at(5'h1B, v); chk("R4 rptr lo readback", v, 8'h02);
  endtask

  task automatic t_unimpl();
    logic [7:0] v;
    pulse_start(); load(5'h1E); wr(8'h55); wr(8'h66); wr(8'h77); pulse_end();
    rd_at(5'h00, v); chk("R10 1Fh->00h step", v, 8'h77);
    rd_at(5'h1E, v); chk("R10 read 1Eh", v, 8'h00);
    rd_at(5'h1F, v); chk("R10 read 1Fh", v, 8'h00);
  endtask

  task automatic t_freeze();
    tick_req = 1; @(negedge clk); tick_req = 0;
    chk("R8 idle tick", {7'd0, time_step}, 8'h01);
    @(negedge clk); chk("R8 single pulse", {7'd0, time_step}, 8'h00);
    pulse_start();
    tick_req = 1; @(negedge clk); tick_req = 0;
    chk("R8 busy tick blocked", {7'd0, time_step}, 8'h00);
    tick_req = 1; @(negedge clk); tick_req = 0;
    chk("R8 busy second tick", {7'd0, time_step}, 8'h00);
    wr(8'h01);
    chk("R8 still frozen", {7'd0, time_step}, 8'h00);
    pulse_end();
    chk("R9 released step", {7'd0, time_step}, 8'h01);
    @(negedge clk); chk("R9 extra dropped", {7'd0, time_step}, 8'h00);
    @(negedge clk); chk("R9 no late step", {7'd0, time_step}, 8'h00);
    pulse_start(); pulse_end();
    chk("R9 empty xfer no step", {7'd0, time_step}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_autoinc();
    t_masks();
    t_ram();
    t_unimpl();
    t_freeze();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule